// File: doc/BRIEF.md
# Floating-Point Coprocessor Instruction Class Decoder

This block sorts a floating-point coprocessor instruction into one of eleven classes before any operand work begins. It looks at the opcode word and the first extension word, together with the processor's supervisor flag. It reports four things: a one-hot class, an illegal-instruction flag, a privilege-violation flag and the instruction length in bytes. It does not decode the effective address, fetch operands or execute anything.

Decoding happens in two steps. A three-bit type field in the opcode word picks the broad family. For the general family (type 0), the extension word is then matched against a prioritised list of masks, so the first match wins and anything unmatched counts as arithmetic. The inputs are captured on a valid strobe. The registered results appear one clock later together with a single-cycle done pulse, and they are held until the next strobe.

Top module: `cpdec_top`

## Requirements
- R1: If bits 15:12 of the opcode word are not all 1, the result is illegal. An illegal result has a class vector of zero and a length of 0.
- R2: Bits 11:9 of the opcode word must equal the coprocessor identifier (default 1). Any other value gives an illegal result.
- R3: Type values (opcode bits 8:6) of 6 and 7 give an illegal result.
- R4: For type 0, the extension word is tested in this order and the first match wins. Bits 15:14 = 11 gives multi-move (class bit 0). Bits 15:14 = 10 gives control move (bit 1). Bits 15:13 = 011 gives store (bit 2). Bits 15:10 = 010111 gives constant load (bit 3). Word AND 0xA07F equal to 0x0026 gives scale (bit 4). Anything else gives arithmetic (bit 5).
- R5: Type 1 gives the conditional group (class bit 8). Type 2 gives a short branch (bit 6). Type 3 gives a long branch (bit 7).
- R6: With the supervisor flag at 1, type 4 gives state save (class bit 9) and type 5 gives state restore (bit 10). Both have a length of 2.
- R7: With the supervisor flag at 0, types 4 and 5 raise the privilege flag instead of a class. The class vector is zero and the length is 2.
- R8: The length is 4 bytes for every legal class except state save, state restore and long branch. A long branch is 6 bytes.
- R9: The done output pulses for exactly one cycle, in the cycle after the valid strobe. The outputs change only on a strobe and hold their values otherwise.
- R10: Illegal takes precedence over the privilege check. A malformed prefix or identifier with type 4 or 5 in user mode raises only the illegal flag.
- R11: At most one class bit is ever set. A legal, privileged result has exactly one class bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Captures the instruction words this cycle |
| opWord | input | 16 | First instruction word |
| extWord | input | 16 | Second instruction word |
| superMode | input | 1 | Processor supervisor flag |
| outDone | output | 1 | One-cycle pulse marking fresh results |
| classOut | output | 11 | One-hot instruction class |
| illegalOut | output | 1 | Illegal instruction |
| privOut | output | 1 | Privilege violation |
| lenOut | output | 4 | Instruction length in bytes |

## Verification
The assertions assume that the input words are settled whenever inValid is high. They also assume that the supervisor flag describes the same instruction that is being captured. The bench drives every input on the falling clock edge and raises inValid only for single, isolated cycles. Between strobes it changes the inputs to unrelated values, so any output that leaks through without a strobe is caught. The type-0 masks are exercised with extension words that match several masks at once. This confirms that the priority order decides the class, not just the presence of a match.

// File: rtl/cpdec_pkg.sv
package cpdec_pkg;
  localparam int CLASS_N = 11;
  localparam int CL_MULTI   = 0;
  localparam int CL_CTRL    = 1;
  localparam int CL_STORE   = 2;
  localparam int CL_CONST   = 3;
  localparam int CL_SCALE   = 4;
  localparam int CL_ARITH   = 5;
  localparam int CL_BSHORT  = 6;
  localparam int CL_BLONG   = 7;
  localparam int CL_COND    = 8;
  localparam int CL_SAVE    = 9;
  localparam int CL_RESTORE = 10;

  localparam int T0_RULES = 5;

  typedef struct packed {
    logic capture;
  } ctrlStrobeS;
endpackage

// File: rtl/cpdec_ctrl.sv
module cpdec_ctrl
  import cpdec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output ctrlStrobeS strobe,
  output logic       outDone
);
  always_comb strobe.capture = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outDone <= 1'b0;
    else       outDone <= inValid;
  end

  a_r9_done_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outDone);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outDone);
endmodule

// File: rtl/cpdec_datapath.sv
module cpdec_datapath
  import cpdec_pkg::*;
#(
  parameter int COPROC_ID = 1,
  parameter int LEN_W     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobeS         strobe,
  input  logic [15:0]        opWord,
  input  logic [15:0]        extWord,
  input  logic               superMode,
  output logic [CLASS_N-1:0] classOut,
  output logic               illegalOut,
  output logic               privOut,
  output logic [LEN_W-1:0]   lenOut
);
  localparam logic [LEN_W-1:0] LEN_BASE  = LEN_W'(4);
  localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(2);
  localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(6);
  localparam logic [2:0]       ID_VAL    = 3'(COPROC_ID);

  localparam logic [15:0] T0_MASK  [T0_RULES] = '{16'hC000, 16'hC000, 16'hE000, 16'hFC00, 16'hA07F};
  localparam logic [15:0] T0_MATCH [T0_RULES] = '{16'hC000, 16'h8000, 16'h6000, 16'h5C00, 16'h0026};

  logic [T0_RULES-1:0] t0Hit;
  for (genvar i = 0; i < T0_RULES; i++) begin : gRule
    assign t0Hit[i] = (extWord & T0_MASK[i]) == T0_MATCH[i];
  end

  logic               prefixOk, idOk;
  logic [2:0]         typeF;
  logic [CLASS_N-1:0] nextClass;
  logic               nextIll, nextPriv, found;
  logic [LEN_W-1:0]   nextLen;

  assign prefixOk = &opWord[15:12];
  assign idOk     = opWord[11:9] == ID_VAL;
  assign typeF    = opWord[8:6];

  always_comb begin
    nextClass = '0;
    nextIll   = 1'b0;
    nextPriv  = 1'b0;
    nextLen   = LEN_BASE;
    found     = 1'b0;
    if (!prefixOk || !idOk) begin
      nextIll = 1'b1;
    end else begin
      case (typeF)
        3'd0: begin
          for (int i = 0; i < T0_RULES; i++) begin
            if (!found && t0Hit[i]) begin
              nextClass[i] = 1'b1;
              found = 1'b1;
            end
          end
          if (!found) nextClass[CL_ARITH] = 1'b1;
        end
        3'd1: nextClass[CL_COND] = 1'b1;
        3'd2: nextClass[CL_BSHORT] = 1'b1;
        3'd3: begin
          nextClass[CL_BLONG] = 1'b1;
          nextLen = LEN_LONG;
        end
        3'd4, 3'd5: begin
          nextLen = LEN_SHORT;
          if (superMode) nextClass[typeF[0] ? CL_RESTORE : CL_SAVE] = 1'b1;
          else           nextPriv = 1'b1;
        end
        default: nextIll = 1'b1;
      endcase
    end
    if (nextIll) begin
      nextClass = '0;
      nextLen   = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      classOut   <= '0;
      illegalOut <= 1'b0;
      privOut    <= 1'b0;
      lenOut     <= '0;
    end else if (strobe.capture) begin
      classOut   <= nextClass;
      illegalOut <= nextIll;
      privOut    <= nextPriv;
      lenOut     <= nextLen;
    end
  end

  a_r1_illegal_empty: assert property (@(posedge clk) disable iff (!rstN)
    illegalOut |-> (classOut == '0 && lenOut == '0 && !privOut));
  a_r7_priv_excl: assert property (@(posedge clk) disable iff (!rstN)
    privOut |-> (classOut == '0 && lenOut == LEN_SHORT));
  a_r11_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(classOut));
  a_r8_long_len: assert property (@(posedge clk) disable iff (!rstN)
    classOut[CL_BLONG] |-> lenOut == LEN_LONG);
  a_r6_save_len: assert property (@(posedge clk) disable iff (!rstN)
    (classOut[CL_SAVE] || classOut[CL_RESTORE]) |-> lenOut == LEN_SHORT);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(classOut) && $stable(lenOut) && $stable(illegalOut) && $stable(privOut)));
endmodule

// File: rtl/cpdec_top.sv
module cpdec_top
  import cpdec_pkg::*;
#(
  parameter int COPROC_ID = 1,
  parameter int LEN_W     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [15:0]        opWord,
  input  logic [15:0]        extWord,
  input  logic               superMode,
  output logic               outDone,
  output logic [CLASS_N-1:0] classOut,
  output logic               illegalOut,
  output logic               privOut,
  output logic [LEN_W-1:0]   lenOut
);
  ctrlStrobeS strobe;

  cpdec_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strobe(strobe), .outDone(outDone)
  );

  cpdec_datapath #(.COPROC_ID(COPROC_ID), .LEN_W(LEN_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opWord(opWord), .extWord(extWord),
    .superMode(superMode), .classOut(classOut), .illegalOut(illegalOut),
    .privOut(privOut), .lenOut(lenOut)
  );
endmodule

// File: tb/cpdec_top_test.sv
module cpdec_top_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic        inValid = 0;
  logic [15:0] opWord = 0, extWord = 0;
  logic        superMode = 0;
  logic        outDone;
  logic [10:0] classOut;
  logic        illegalOut, privOut;
  logic [3:0]  lenOut;
  int          nRun = 0, nFail = 0;

  always #10 clk = ~clk;

  cpdec_top uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opWord(opWord), .extWord(extWord),
    .superMode(superMode), .outDone(outDone), .classOut(classOut),
    .illegalOut(illegalOut), .privOut(privOut), .lenOut(lenOut)
  );

  task automatic check(string tag, logic [17:0] act, logic [17:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] pack(int cls, logic ill, logic prv, logic [3:0] len);
    logic [10:0] c = (cls < 0) ? 11'd0 : (11'd1 << cls);
    return {1'b0, c, ill, prv, len};
  endfunction

  task automatic runOp(string tag, logic [15:0] op, logic [15:0] ext, logic sup,
                       int cls, logic ill, logic prv, logic [3:0] len);
    logic [17:0] snap;
    @(negedge clk);
    opWord = op; extWord = ext; superMode = sup; inValid = 1;
    @(negedge clk);
    inValid = 0; opWord = ~op; extWord = ~ext; superMode = ~sup;
    check({tag, " done"}, {17'd0, outDone}, 18'd1);
    snap = {1'b0, classOut, illegalOut, privOut, lenOut};
    check(tag, snap, pack(cls, ill, prv, len));
    @(negedge clk);
    check({tag, " R9 pulse"}, {17'd0, outDone}, 18'd0);
    check({tag, " R9 hold"}, {1'b0, classOut, illegalOut, privOut, lenOut}, snap);
  endtask

  initial begin
    #2000000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("reset R9", {1'b0, classOut, illegalOut, privOut, lenOut}, 18'd0);
    check("reset done R9", {17'd0, outDone}, 18'd0);
    rstN = 1;
    // R4 priority
    runOp("R4 multi",  16'hF200, 16'hC026, 0, 0, 0, 0, 4);
    runOp("R4 ctrl",   16'hF200, 16'h8000, 0, 1, 0, 0, 4);
    runOp("R4 store",  16'hF200, 16'h6026, 0, 2, 0, 0, 4);
    runOp("R4 const",  16'hF200, 16'h5C26, 0, 3, 0, 0, 4);
    runOp("R4 scale",  16'hF200, 16'h4026, 0, 4, 0, 0, 4);
    runOp("R4 arith",  16'hF200, 16'h0022, 0, 5, 0, 0, 4);
    // R5 and R8
    runOp("R5 cond",   16'hF240, 16'h0001, 0, 8, 0, 0, 4);
    runOp("R5 bshort", 16'hF280, 16'h0010, 0, 6, 0, 0, 4);
    runOp("R8 blong",  16'hF2C0, 16'h0000, 1, 7, 0, 0, 6);
    // R6 / R7
    runOp("R6 save",    16'hF300, 16'h0000, 1, 9, 0, 0, 2);
    runOp("R6 restore", 16'hF340, 16'h0000, 1, 10, 0, 0, 2);
    runOp("R7 save",    16'hF300, 16'h0000, 0, -1, 0, 1, 2);
    runOp("R7 restore", 16'hF340, 16'h0000, 0, -1, 0, 1, 2);
    // R1 / R2 / R3 / R10
    runOp("R1 prefix",  16'hE200, 16'h0000, 1, -1, 1, 0, 0);
    runOp("R2 id",      16'hF400, 16'hC000, 1, -1, 1, 0, 0);
    runOp("R2 id0",     16'hF000, 16'h0000, 1, -1, 1, 0, 0);
    runOp("R3 type6",   16'hF380, 16'h0000, 1, -1, 1, 0, 0);
    runOp("R3 type7",   16'hF3C0, 16'h0000, 1, -1, 1, 0, 0);
    runOp("R10 prefix", 16'h7300, 16'h0000, 0, -1, 1, 0, 0);
    runOp("R10 id",     16'hF740, 16'h0000, 0, -1, 1, 0, 0);
    runOp("R11 arith",  16'hF23F, 16'h003A, 0, 5, 0, 0, 4);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule